// File: doc/BRIEF.md
# Multi-Shot Acquisition Sequencer

The sequencer is the command-driven control core of a four-channel sampling front end. Software issues start and stop commands through a small command field. After a start, the block collects a configured number of pre-trigger samples, waits for a trigger, collects a configured number of post-trigger samples, and closes the shot. It repeats this for the configured number of shots. It raises a one-cycle pulse for every accepted trigger and one more pulse when the whole acquisition ends. It also reports how many shots are still outstanding.

Each accepted sample is a single word in which the four channels sit side by side, and the block emits one write per sample. A single-shot acquisition writes into a large external memory, which the block addresses as a ring. A multi-shot acquisition instead alternates between two on-chip buffers, switching buffer at every shot. In that mode the last two slots of each buffer are kept free for a time-tag, so the depth the block advertises is the buffer depth minus two. The buffer depth is a build-time parameter and cannot be changed at run time.

Top module: `acq_seq`

## Requirements
- R1: After reset, state_o is 0 (idle), shots_left_o is 0, and wr_en_o, trig_evt_o and acq_end_evt_o are all low.
- R2: With cmd_valid_i high and cmd_i = 2'b01 (start) in idle, a nonzero shots_cfg_i moves state_o to 1 (pre-trigger) at the next edge and loads shots_left_o with shots_cfg_i. A shots_cfg_i of 0 leaves the block in idle.
- R3: A trigger is acted on only in state 2 (waiting for trigger). There it moves the block to state 3 (post-trigger) and pulses trig_evt_o for the one following cycle. A trigger seen in any other state has no effect.
- R4: With N shots configured, an acquisition produces exactly N trigger pulses and then exactly one acq_end_evt_o pulse. The end pulse comes as the block returns to idle after the last shot.
- R5: shots_left_o decreases by one each time a shot completes, in state 4, and reads 0 once the acquisition has finished.
- R6: cmd_i = 2'b10 (stop) with cmd_valid_i returns the block to idle at the next edge from any state, without an end pulse.
- R7: A start command given while an acquisition is running changes neither the state nor shots_left_o.
- R8: While sample_valid_i is high, a write is issued in the following cases: while fewer than the latched pre-trigger count have been written in state 1; on every cycle in state 2; and while fewer than the latched post-trigger count have been written in state 3. No other cycle issues a write.
- R9: When more than one shot is configured, wr_buf_o is 0 for the first shot and toggles for each later shot. wr_addr_o restarts at 0 for each shot and wraps within the first BUF_DEPTH-2 slots.
- R10: With a single shot configured, wr_buf_o stays 0 and wr_addr_o wraps as a ring over EXT_DEPTH entries.
- R11: max_depth_o equals BUF_DEPTH-2.
- R12: wr_data_o holds the four channels interleaved, with channel i in bits [i*DW +: DW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code: 01 start, 10 stop |
| shots_cfg_i | input | SHOT_W | Number of shots, latched at start |
| pre_cfg_i | input | ADDR_W | Pre-trigger sample count, latched at start |
| post_cfg_i | input | ADDR_W | Post-trigger sample count, latched at start |
| trig_i | input | 1 | Trigger |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | NCH*DW | Four channel samples |
| wr_en_o | output | 1 | Sample write |
| wr_buf_o | output | 1 | Selected on-chip buffer |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | NCH*DW | Interleaved sample word |
| trig_evt_o | output | 1 | Trigger accepted pulse |
| acq_end_evt_o | output | 1 | Acquisition end pulse |
| shots_left_o | output | SHOT_W | Shots still to acquire |
| state_o | output | 3 | 0 idle, 1 pre, 2 wait, 3 post, 4 shot done |
| max_depth_o | output | BUF_AW | Usable multi-shot depth |

## Verification
The hardest case to reach is a multi-shot run in which a single shot writes more samples than a buffer can hold. Only that case shows the address wrap below the reserved time-tag slots, and the bench has to show it together with the buffer toggle and the address restart at the next shot. To reach it, the bench holds sample_valid_i high throughout and watches state_o. It releases the trigger a set number of cycles after the wait state begins. Each shot then writes an exact, known number of samples that is larger than the buffer. The stop and ignored-start cases run with samples held off, so the block can be parked in the pre-trigger, wait and post-trigger states.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } acq_state_e;

  localparam logic [1:0] CMD_START = 2'b01;
  localparam logic [1:0] CMD_STOP  = 2'b10;
endpackage

// File: rtl/acq_seq_win.sv
module acq_seq_win #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == limit_i);

  assert_win_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/acq_seq_addr.sv
module acq_seq_addr #(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 16,
  parameter int EXT_DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              clr_buf_i,
  input  logic              flip_i,
  input  logic              multi_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              buf_o
);
  // two top slots of each on-chip buffer hold the time-tag
  localparam logic [ADDR_W-1:0] BUF_LAST = ADDR_W'(BUF_DEPTH - 3);
  localparam logic [ADDR_W-1:0] EXT_LAST = ADDR_W'(EXT_DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, last;
  logic              buf_q;

  assign last = multi_i ? BUF_LAST : EXT_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (restart_i) addr_q <= '0;
    else if (inc_i)     addr_q <= (addr_q == last) ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        buf_q <= 1'b0;
    else if (clr_buf_i) buf_q <= 1'b0;
    else if (flip_i)    buf_q <= ~buf_q;
  end

  assign addr_o = addr_q;
  assign buf_o  = buf_q;

  assert_multi_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && multi_i) |-> (addr_q < ADDR_W'(BUF_DEPTH - 2)));
  assert_restart_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (addr_q == '0));
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int SHOT_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [SHOT_W-1:0] shots_cfg_i,
  input  logic [CNT_W-1:0]  pre_cfg_i,
  input  logic [CNT_W-1:0]  post_cfg_i,
  input  logic              trig_i,
  input  logic              pre_done_i,
  input  logic              post_done_i,
  output acq_state_e        state_o,
  output logic [SHOT_W-1:0] shots_left_o,
  output logic [CNT_W-1:0]  pre_lim_o,
  output logic [CNT_W-1:0]  post_lim_o,
  output logic              multi_o,
  output logic              start_o,
  output logic              next_shot_o,
  output logic              trig_evt_o,
  output logic              acq_end_evt_o
);
  acq_state_e        state_q;
  logic [SHOT_W-1:0] shots_q;
  logic [CNT_W-1:0]  pre_q, post_q;
  logic              multi_q, trig_evt_q, end_evt_q;
  logic              start, stop;

  assign stop        = cmd_valid_i && (cmd_i == CMD_STOP);
  assign start       = cmd_valid_i && (cmd_i == CMD_START) && (state_q == ST_IDLE)
                       && (shots_cfg_i != '0);
  assign next_shot_o = (state_q == ST_DONE) && (shots_q != SHOT_W'(1)) && !stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shots_q    <= '0;
      pre_q      <= '0;
      post_q     <= '0;
      multi_q    <= 1'b0;
      trig_evt_q <= 1'b0;
      end_evt_q  <= 1'b0;
    end else begin
      trig_evt_q <= 1'b0;
      end_evt_q  <= 1'b0;
      if (stop) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start) begin
            state_q <= ST_PRE;
            shots_q <= shots_cfg_i;
            pre_q   <= pre_cfg_i;
            post_q  <= post_cfg_i;
            multi_q <= (shots_cfg_i > SHOT_W'(1));
          end
          ST_PRE:  if (pre_done_i) state_q <= ST_WAIT;
          ST_WAIT: if (trig_i) begin
            state_q    <= ST_POST;
            trig_evt_q <= 1'b1;
          end
          ST_POST: if (post_done_i) state_q <= ST_DONE;
          ST_DONE: begin
            shots_q <= shots_q - 1'b1;
            if (shots_q == SHOT_W'(1)) begin
              state_q   <= ST_IDLE;
              end_evt_q <= 1'b1;
            end else begin
              state_q <= ST_PRE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o       = state_q;
  assign shots_left_o  = shots_q;
  assign pre_lim_o     = pre_q;
  assign post_lim_o    = post_q;
  assign multi_o       = multi_q;
  assign start_o       = start;
  assign trig_evt_o    = trig_evt_q;
  assign acq_end_evt_o = end_evt_q;

  assert_zero_shots_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cmd_valid_i && cmd_i == CMD_START && shots_cfg_i == '0)
    |=> (state_q == ST_IDLE));
  assert_trig_only_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_evt_q |-> $past(state_q == ST_WAIT && trig_i));
  assert_end_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_evt_q |-> (shots_q == '0 && state_q == ST_IDLE));
  assert_shot_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !stop) |=> (shots_q == $past(shots_q) - 1'b1));
  assert_stop_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state_q == ST_IDLE && !end_evt_q));
  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_START && state_q != ST_IDLE && state_q != ST_DONE)
    |=> $stable(shots_q));
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_seq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 14,
  parameter int BUF_DEPTH = 16,
  parameter int EXT_DEPTH = 64,
  parameter int SHOT_W    = 8,
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int EXT_AW   = $clog2(EXT_DEPTH),
  localparam int ADDR_W   = (EXT_AW > BUF_AW) ? EXT_AW : BUF_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [SHOT_W-1:0] shots_cfg_i,
  input  logic [ADDR_W-1:0] pre_cfg_i,
  input  logic [ADDR_W-1:0] post_cfg_i,
  input  logic              trig_i,
  input  logic              sample_valid_i,
  input  logic [NCH*DW-1:0] sample_i,
  output logic              wr_en_o,
  output logic              wr_buf_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [NCH*DW-1:0] wr_data_o,
  output logic              trig_evt_o,
  output logic              acq_end_evt_o,
  output logic [SHOT_W-1:0] shots_left_o,
  output logic [2:0]        state_o,
  output logic [BUF_AW-1:0] max_depth_o
);
  acq_state_e        state;
  logic [ADDR_W-1:0] pre_lim, post_lim;
  logic              multi, start, next_shot;
  logic              pre_done, post_done;
  logic              in_pre, in_wait, in_post, wr_en;

  acq_seq_fsm #(.SHOT_W(SHOT_W), .CNT_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .shots_cfg_i, .pre_cfg_i, .post_cfg_i, .trig_i,
    .pre_done_i   (pre_done),
    .post_done_i  (post_done),
    .state_o      (state),
    .shots_left_o,
    .pre_lim_o    (pre_lim),
    .post_lim_o   (post_lim),
    .multi_o      (multi),
    .start_o      (start),
    .next_shot_o  (next_shot),
    .trig_evt_o,
    .acq_end_evt_o
  );

  assign in_pre  = (state == ST_PRE);
  assign in_wait = (state == ST_WAIT);
  assign in_post = (state == ST_POST);
  assign wr_en   = sample_valid_i &&
                   ((in_pre && !pre_done) || in_wait || (in_post && !post_done));

  acq_seq_win #(.W(ADDR_W)) u_pre_win (
    .clk_i, .rst_ni,
    .clr_i   (!in_pre),
    .inc_i   (in_pre && sample_valid_i && !pre_done),
    .limit_i (pre_lim),
    .done_o  (pre_done)
  );

  acq_seq_win #(.W(ADDR_W)) u_post_win (
    .clk_i, .rst_ni,
    .clr_i   (!in_post),
    .inc_i   (in_post && sample_valid_i && !post_done),
    .limit_i (post_lim),
    .done_o  (post_done)
  );

  acq_seq_addr #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_addr (
    .clk_i, .rst_ni,
    .restart_i (start || next_shot),
    .clr_buf_i (start),
    .flip_i    (next_shot && multi),
    .multi_i   (multi),
    .inc_i     (wr_en),
    .addr_o    (wr_addr_o),
    .buf_o     (wr_buf_o)
  );

  // one sample word per write, channel i in lane i
  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign wr_data_o[g*DW +: DW] = sample_i[g*DW +: DW];
  end

  assign wr_en_o     = wr_en;
  assign state_o     = state;
  assign max_depth_o = BUF_AW'(BUF_DEPTH - 2);

  assert_no_write_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE || state == ST_DONE) |-> !wr_en_o);
  assert_single_bank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !multi) |-> !wr_buf_o);
endmodule

// File: tb/tb_acq_seq.sv
module tb_acq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DWT = 56;

  logic            clk_i = 0, rst_ni = 0;
  logic            cmd_valid_i = 0;
  logic [1:0]      cmd_i = '0;
  logic [7:0]      shots_cfg_i = '0;
  logic [AW-1:0]   pre_cfg_i = '0, post_cfg_i = '0;
  logic            trig_i = 0, sample_valid_i = 0;
  logic [DWT-1:0]  sample_i = '0;
  logic            wr_en_o, wr_buf_o, trig_evt_o, acq_end_evt_o;
  logic [AW-1:0]   wr_addr_o;
  logic [DWT-1:0]  wr_data_o;
  logic [7:0]      shots_left_o;
  logic [2:0]      state_o;
  logic [3:0]      max_depth_o;

  acq_seq dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0, trig_cnt = 0, end_cnt = 0;
  bit finished = 0;
  logic [AW+DWT:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every write
  always @(negedge clk_i) if (rst_ni) begin
    if (trig_evt_o) trig_cnt++;
    if (acq_end_evt_o) end_cnt++;
    if (wr_en_o) begin
      if (exp_q.size() == 0) chk(0, "R8", "unexpected write", {wr_buf_o, wr_addr_o}, 0);
      else begin
        logic [AW+DWT:0] e, a;
        e = exp_q.pop_front();
        a = {wr_buf_o, wr_addr_o, wr_data_o};
        chk(a == e, "R9_R10_R12", "write buf/addr/data", 64'(a >> DWT), 64'(e >> DWT));
        chk(a[DWT-1:0] == e[DWT-1:0], "R12", "interleaved word", 64'(a[DWT-1:0]), 64'(e[DWT-1:0]));
      end
    end
  end

  task automatic tick(); @(negedge clk_i); #1; endtask

  task automatic push_shot(input int n, input bit b, input bit multi, input logic [DWT-1:0] d);
    int wrap = multi ? 14 : 64;
    for (int i = 0; i < n; i++) exp_q.push_back({b, AW'(i % wrap), d});
  endtask

  task automatic send_cmd(input logic [1:0] c);
    cmd_valid_i = 1; cmd_i = c; tick(); cmd_valid_i = 0;
  endtask

  task automatic run_acq(input int n, input int pre, input int k, input int post,
                         input bit early, input int tag);
    logic [13:0] ch[4];
    bit multi = (n > 1);
    for (int i = 0; i < 4; i++) ch[i] = 14'(tag * 16 + i + 1);
    sample_i = {ch[3], ch[2], ch[1], ch[0]};
    shots_cfg_i = 8'(n); pre_cfg_i = AW'(pre); post_cfg_i = AW'(post);
    trig_cnt = 0; end_cnt = 0; sample_valid_i = 1;
    push_shot(pre + k + 1 + post, 1'b0, multi, sample_i);
    send_cmd(2'b01);
    chk(state_o == 3'd1, "R2", "state after start", state_o, 1);
    chk(shots_left_o == 8'(n), "R2", "shots loaded", shots_left_o, n);
    if (early) begin
      trig_i = 1; tick(); trig_i = 0;
      chk(state_o == 3'd1, "R3", "trigger in pre ignored", state_o, 1);
      chk(trig_cnt == 0, "R3", "no trig pulse in pre", trig_cnt, 0);
    end
    for (int s = 0; s < n; s++) begin
      if (s > 0) push_shot(pre + k + 1 + post, multi ? 1'(s % 2) : 1'b0, multi, sample_i);
      while (state_o != 3'd2) tick();
      repeat (k) tick();
      trig_i = 1; tick(); trig_i = 0;
      chk(state_o == 3'd3, "R3", "post after trigger", state_o, 3);
      chk(trig_cnt == s + 1, "R3", "trig pulse", trig_cnt, s + 1);
      chk(shots_left_o == 8'(n - s), "R5", "shots left before done", shots_left_o, n - s);
    end
    while (state_o != 3'd0) tick();
    repeat (3) tick();
    sample_valid_i = 0;
    chk(end_cnt == 1, "R4", "end pulses", end_cnt, 1);
    chk(trig_cnt == n, "R4", "trig pulses", trig_cnt, n);
    chk(shots_left_o == 0, "R5", "shots left at end", shots_left_o, 0);
    chk(exp_q.size() == 0, "R8", "pending writes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(state_o == 0, "R1", "reset state", state_o, 0);
    chk(shots_left_o == 0, "R1", "reset shots", shots_left_o, 0);
    chk(!wr_en_o && !trig_evt_o && !acq_end_evt_o, "R1", "reset outputs",
        {wr_en_o, trig_evt_o, acq_end_evt_o}, 0);
    chk(max_depth_o == 4'd14, "R11", "max depth", max_depth_o, 14);
    rst_ni = 1; tick();

    // R2 zero shots rejected
    shots_cfg_i = 0; send_cmd(2'b01);
    chk(state_o == 0, "R2", "zero shots stays idle", state_o, 0);
    chk(shots_left_o == 0, "R2", "zero shots count", shots_left_o, 0);

    run_acq(1, 0, 2, 1, 0, 1);     // R10 short single shot
    run_acq(2, 5, 0, 3, 1, 2);     // R3 early trigger, R9 toggle
    run_acq(3, 6, 5, 6, 0, 3);     // R9 wrap in each buffer
    run_acq(1, 30, 20, 30, 0, 4);  // R10 ring wrap over 64

    // R7 and R6 with samples held off
    trig_cnt = 0; end_cnt = 0;
    shots_cfg_i = 3; pre_cfg_i = 0; post_cfg_i = 0;
    send_cmd(2'b01);
    while (state_o != 3'd2) tick();
    shots_cfg_i = 7; send_cmd(2'b01);
    chk(state_o == 3'd2, "R7", "start while busy state", state_o, 2);
    chk(shots_left_o == 3, "R7", "start while busy shots", shots_left_o, 3);
    send_cmd(2'b10);
    chk(state_o == 0, "R6", "stop from wait", state_o, 0);
    repeat (3) tick();
    chk(end_cnt == 0, "R6", "no end on stop", end_cnt, 0);

    shots_cfg_i = 2; pre_cfg_i = 4; send_cmd(2'b01);
    chk(state_o == 3'd1, "R6", "parked in pre", state_o, 1);
    send_cmd(2'b10);
    chk(state_o == 0, "R6", "stop from pre", state_o, 0);

    pre_cfg_i = 0; post_cfg_i = 3; send_cmd(2'b01);
    while (state_o != 3'd2) tick();
    trig_i = 1; tick(); trig_i = 0;
    chk(state_o == 3'd3, "R6", "parked in post", state_o, 3);
    send_cmd(2'b10);
    chk(state_o == 0, "R6", "stop from post", state_o, 0);
    repeat (3) tick();
    chk(end_cnt == 0, "R6", "no end after post stop", end_cnt, 0);
    chk(exp_q.size() == 0, "R8", "no stray writes", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule